// File: doc/BRIEF.md
# Reset Pin Controller with Cause Discrimination

This block sits behind a shared, active-low reset pin that works as an input and also as an open-drain output. When an on-chip fault is flagged, it pulls the pin low. The fault is either a clock-monitor failure or a watchdog timeout. The pin stays low for a fixed number of E-clock periods. After that the block releases the pin and times how quickly the pin returns high.

- If the pin recovers inside a short window, the reset was the block's own, and the fault cause is kept.
- If the pin is still held low at the end of the window, something outside is holding it, and the reset is reported as external.

The core reset output covers the whole episode. It falls only on an E-clock tick, with the pin high. A two-bit cause code tells the core which of the three sources started the last reset. All timing advances on an E-clock enable, which is one input-clock cycle in four when no PLL is used. The raw pin reading is synchronized before it is used.

Top module: `rstpin_ctrl`

## Requirements
- R1: While `rst_n` is low, `pin_oe` is 0, `core_rst` is 1 and `cause` is 2'b00.
- R2: `pin_oe` (1 = pull the pin low, 0 = release) only rises while the core reset is deasserted. It never rises during a reset seen on the pin from outside. The block has no way to drive the pin high.
- R3: The cause code is one of three values: 2'b00 external, 2'b01 clock monitor, 2'b10 watchdog. 2'b11 never appears.
- R4: A fault input asserted while idle (core reset low, pin high) sets `pin_oe` and `core_rst` on the next clock. In the same clock the cause becomes the fault's code.
- R5: Once a fault is taken, `pin_oe` stays high for exactly `HOLD_E` E-clock ticks.
- R6: A low pin level, after synchronization, asserts `core_rst` on the following clock. A reset that starts from the pin sets the cause to 2'b00.
- R7: After the pin is released, `WIN_E` ticks form a window. If the synchronized pin reads high on any of ticks 1 to `WIN_E`-1, the fault cause is kept. Otherwise the cause becomes 2'b00 and the core reset waits for the pin to go high.
- R8: If both fault inputs assert in the same cycle, the clock-monitor code 2'b01 wins.
- R9: `core_rst` deasserts only on a clock where `e_en` is high and the synchronized pin is high. While `core_rst` stays low, the cause does not change.
- R10: Fault inputs are ignored while the core reset is asserted. They neither set `pin_oe` nor alter the cause.
- R11: The pin input passes through `SYNC_STAGES` flip-flops before use. With two stages, a pin falling before clock edge 1 raises `core_rst` at edge 3 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| e_en | input | 1 | E-clock enable, one clock in four |
| pin_in | input | 1 | Raw level read back from the reset pin |
| flt_cm | input | 1 | Clock-monitor failure request |
| flt_wd | input | 1 | Watchdog timeout request |
| pin_oe | output | 1 | Open-drain pull-down enable for the reset pin |
| core_rst | output | 1 | Reset to the core, active high |
| cause | output | 2 | Source of the last reset (00 ext, 01 clock monitor, 10 watchdog) |

## Verification
The bench builds the block with `HOLD_E` set to 6, `WIN_E` left at 4 and `SYNC_STAGES` at 2. With a hold of 6 ticks, the exact-length check on the pull-down completes in a few dozen clocks. The two-stage synchronizer makes the edge-3 response to a falling pin a fixed point the bench can probe. With the window at 4 ticks, the bench can separate two cases in a short run: a pin freed about two ticks after release is classed as internal, and one held for several windows is classed as external.

// File: rtl/rstpin_pkg.sv
package rstpin_pkg;

   typedef enum logic [1:0] {
      CAUSE_EXT  = 2'b00,
      CAUSE_CMON = 2'b01,
      CAUSE_WDOG = 2'b10
   } cause_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DRIVE = 2'd1,
      ST_WIN   = 2'd2,
      ST_EXT   = 2'd3
   } phase_e;

endpackage

// File: rtl/rstpin_sync.sv
module rstpin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rstpin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   // Reset to 0: the pin counts as low until it has been seen high.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rstpin_tick_cnt.sv
module rstpin_tick_cnt #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   output logic [CW-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/rstpin_fsm.sv
module rstpin_fsm
   import rstpin_pkg::*;
#(
   parameter int HOLD_E = 16,
   parameter int WIN_E  = 4,
   parameter int CW     = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          e_en,
   input  logic          pin_s,
   input  logic          flt_cm,
   input  logic          flt_wd,
   input  logic [CW-1:0] cnt,
   output logic          cnt_clr,
   output logic          pin_oe,
   output logic          core_rst,
   output logic [1:0]    cause
);
   phase_e st, st_nxt;
   cause_e cs, cs_nxt;
   logic   seen_hi, seen_nxt;
   logic   hold_end, win_end;

   assign hold_end = e_en && (cnt == CW'(HOLD_E - 1));
   assign win_end  = e_en && (cnt == CW'(WIN_E - 1));

   always_comb begin
      st_nxt   = st;
      cs_nxt   = cs;
      seen_nxt = seen_hi;
      cnt_clr  = 1'b0;
      unique case (st)
         ST_IDLE: begin
            cnt_clr = 1'b1;
            if (!pin_s) begin
               st_nxt = ST_EXT;
               cs_nxt = CAUSE_EXT;
            end else if (flt_cm) begin
               st_nxt = ST_DRIVE;
               cs_nxt = CAUSE_CMON;
            end else if (flt_wd) begin
               st_nxt = ST_DRIVE;
               cs_nxt = CAUSE_WDOG;
            end
         end
         ST_DRIVE: begin
            if (hold_end) begin
               st_nxt   = ST_WIN;
               cnt_clr  = 1'b1;
               seen_nxt = 1'b0;
            end
         end
         ST_WIN: begin
            if (e_en && pin_s && !win_end) seen_nxt = 1'b1;
            if (win_end) begin
               st_nxt  = pin_s ? ST_IDLE : ST_EXT;
               cnt_clr = 1'b1;
               if (!seen_hi) cs_nxt = CAUSE_EXT;
            end
         end
         ST_EXT: begin
            cnt_clr = 1'b1;
            if (e_en && pin_s) st_nxt = ST_IDLE;
         end
         default: st_nxt = ST_EXT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_EXT;
         cs       <= CAUSE_EXT;
         seen_hi  <= 1'b0;
         core_rst <= 1'b1;
      end else begin
         st       <= st_nxt;
         cs       <= cs_nxt;
         seen_hi  <= seen_nxt;
         core_rst <= (st_nxt != ST_IDLE);
      end
   end

   assign pin_oe = (st == ST_DRIVE);
   assign cause  = cs;
endmodule

// File: rtl/rstpin_ctrl.sv
module rstpin_ctrl #(
   parameter int HOLD_E      = 16,
   parameter int WIN_E       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       e_en,
   input  logic       pin_in,
   input  logic       flt_cm,
   input  logic       flt_wd,
   output logic       pin_oe,
   output logic       core_rst,
   output logic [1:0] cause
);
   localparam int MAXC = (HOLD_E > WIN_E) ? HOLD_E : WIN_E;
   localparam int CW   = $clog2(MAXC);

   generate
      if (HOLD_E < 2) begin : g_bad_hold
         $error("rstpin_ctrl: HOLD_E must be at least 2");
      end
      if (WIN_E < 2) begin : g_bad_win
         $error("rstpin_ctrl: WIN_E must be at least 2");
      end
   endgenerate

   logic          pin_s;
   logic          cnt_clr;
   logic [CW-1:0] cnt;

   rstpin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_s)
   );

   rstpin_tick_cnt #(.CW(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .tick  (e_en),
      .cnt   (cnt)
   );

   rstpin_fsm #(.HOLD_E(HOLD_E), .WIN_E(WIN_E), .CW(CW)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .e_en     (e_en),
      .pin_s    (pin_s),
      .flt_cm   (flt_cm),
      .flt_wd   (flt_wd),
      .cnt      (cnt),
      .cnt_clr  (cnt_clr),
      .pin_oe   (pin_oe),
      .core_rst (core_rst),
      .cause    (cause)
   );
endmodule

// File: rtl/rstpin_chk.sv
module rstpin_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       e_en,
   input logic       pin_s,
   input logic       flt_cm,
   input logic       flt_wd,
   input logic       pin_oe,
   input logic       core_rst,
   input logic [1:0] cause
);
   a_r3_cause_legal: assert property (@(posedge clk) disable iff (!rst_n)
      cause != 2'b11);

   a_r2_oe_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pin_oe) |-> $past(!core_rst));

   a_r4_fault_pulls: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_rst && pin_s && (flt_cm || flt_wd)) |=> (pin_oe && core_rst));

   a_r8_cmon_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_rst && pin_s && flt_cm && flt_wd) |=> (cause == 2'b01));

   a_r6_low_pin_resets: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_s |=> core_rst);

   a_r9_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_rst) |-> $past(e_en && pin_s));

   a_r9_cause_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_rst ##1 !core_rst) |-> $stable(cause));

   a_r10_no_late_pull: assert property (@(posedge clk) disable iff (!rst_n)
      (core_rst && !pin_oe) |=> !pin_oe);
endmodule

bind rstpin_ctrl rstpin_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .e_en     (e_en),
   .pin_s    (pin_s),
   .flt_cm   (flt_cm),
   .flt_wd   (flt_wd),
   .pin_oe   (pin_oe),
   .core_rst (core_rst),
   .cause    (cause)
);

// File: tb/sim_rstpin_ctrl.sv
`timescale 1ns/1ps
module sim_rstpin_ctrl;
   localparam int HOLD = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       e_en = 1'b0;
   logic       flt_cm = 1'b0;
   logic       flt_wd = 1'b0;
   logic       ext_low = 1'b0;
   logic       pin_oe, core_rst;
   logic [1:0] cause;
   wire        pin_in = !(pin_oe || ext_low);

   int n_chk = 0, n_bad = 0;
   int hold_cnt = 0;
   bit oe_seen = 1'b0;
   bit done = 1'b0;
   logic [1:0] exp_q[$];

   always #2 clk = ~clk;

   rstpin_ctrl #(.HOLD_E(HOLD), .WIN_E(4), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .e_en(e_en), .pin_in(pin_in),
      .flt_cm(flt_cm), .flt_wd(flt_wd),
      .pin_oe(pin_oe), .core_rst(core_rst), .cause(cause)
   );

   task automatic chk(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   // E-clock enable generator; also counts ticks taken while pulling low.
   initial begin
      int div = 0;
      forever begin
         @(negedge clk);
         div = (div + 1) % 4;
         e_en = (div == 0);
         if (e_en && pin_oe) hold_cnt++;
         if (pin_oe) oe_seen = 1'b1;
      end
   end

   // Scoreboard monitor: pop expected cause on each core reset release.
   initial begin
      logic prev = 1'b1;
      forever begin
         @(negedge clk);
         if (rst_n && prev && !core_rst) begin
            if (exp_q.size() == 0) chk("R9 unexpected release", 1, 0);
            else chk("R7 cause at release", cause, exp_q.pop_front());
         end
         prev = core_rst;
      end
   end

   task automatic pulse(input logic cm, input logic wd);
      @(negedge clk); flt_cm = cm; flt_wd = wd;
      @(negedge clk); flt_cm = 1'b0; flt_wd = 1'b0;
   endtask

   task automatic wait_idle(input string req);
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (!core_rst) return;
      end
      chk({req, " release timeout"}, 0, 1);
   endtask

   task automatic wait_oe_low();
      for (int i = 0; i < 2000; i++) begin
         if (!pin_oe) return;
         @(negedge clk);
      end
   endtask

   initial begin
      #(4 * 100000);
      chk("watchdog", 0, 1);
      if (!done) begin
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      chk("R1 pin_oe in reset", pin_oe, 0);
      chk("R1 core_rst in reset", core_rst, 1);
      chk("R1 cause in reset", cause, 0);
      exp_q.push_back(2'b00);
      rst_n = 1'b1;
      wait_idle("R9 power-up");
      chk("R9 idle after power-up", core_rst, 0);

      // Watchdog fault, pin recovers at once: internal.
      hold_cnt = 0;
      exp_q.push_back(2'b10);
      pulse(1'b0, 1'b1);
      chk("R4 pin_oe after fault", pin_oe, 1);
      chk("R4 core_rst after fault", core_rst, 1);
      chk("R3 watchdog code", cause, 2);
      wait_idle("R7 watchdog");
      chk("R5 hold length watchdog", hold_cnt, HOLD);

      // Clock-monitor fault.
      hold_cnt = 0;
      exp_q.push_back(2'b01);
      pulse(1'b1, 1'b0);
      chk("R3 clock-monitor code", cause, 1);
      wait_idle("R7 clock monitor");
      chk("R5 hold length clock monitor", hold_cnt, HOLD);

      // Both faults at once.
      exp_q.push_back(2'b01);
      pulse(1'b1, 1'b1);
      chk("R8 priority", cause, 1);
      wait_idle("R8 both");

      // Pin held low from outside past the window: external.
      exp_q.push_back(2'b00);
      pulse(1'b0, 1'b1);
      ext_low = 1'b1;
      wait_oe_low();
      repeat (30) @(negedge clk);
      chk("R7 late pin keeps core reset", core_rst, 1);
      chk("R7 late pin cause", cause, 0);
      ext_low = 1'b0;
      wait_idle("R7 late");

      // Pin freed about two ticks after release: still internal.
      exp_q.push_back(2'b10);
      pulse(1'b0, 1'b1);
      ext_low = 1'b1;
      wait_oe_low();
      repeat (5) @(negedge clk);
      ext_low = 1'b0;
      wait_idle("R7 early");
      chk("R7 early cause kept", cause, 2);

      // External reset from idle, with a fault during it.
      oe_seen = 1'b0;
      exp_q.push_back(2'b00);
      ext_low = 1'b1;
      repeat (2) @(negedge clk);
      chk("R11 not yet through synchronizer", core_rst, 0);
      @(negedge clk);
      chk("R6 core_rst from pin", core_rst, 1);
      chk("R6 external code", cause, 0);
      pulse(1'b0, 1'b1);
      repeat (4) @(negedge clk);
      chk("R10 fault ignored pin_oe", pin_oe, 0);
      chk("R10 fault ignored cause", cause, 0);
      chk("R2 no pull during external", oe_seen, 0);
      ext_low = 1'b0;
      wait_idle("R6 external");

      // Quiet period: cause must hold.
      repeat (20) @(negedge clk);
      chk("R9 cause steady", cause, 0);
      chk("R9 stays idle", core_rst, 0);
      chk("scoreboard drained", exp_q.size(), 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule